// File: doc/BRIEF.md
# CEC Receive Acceptance and Error-Bit Policy

This block sits behind the waveform decoder of a consumer-electronics-control receiver. For each incoming frame it looks at the decoded destination address of the header. From that address, the own-address mask and the listening mode, it decides whether the frame is taken in and whether the device should drive an acknowledge. While the frame runs, the decoder reports timing errors as one-cycle strobes. The block decides, per error, whether to request an error-bit on the line and whether to abandon the reception.

The own address is a one-hot mask, so the device can answer to several logical addresses at the same time. Destination 15 is the broadcast address. Broadcast frames are always taken in. They get no acknowledge drive, because a broadcast frame is acknowledged by leaving the line alone. Broadcast frames follow their own error-bit rules, and those rules override the per-error enables. A set of sticky flags records what happened during reception. Software clears a flag by writing 1 to it.

Top module: `cec_rx_policy`

## Requirements
- R1: A header whose destination bit is set in `cfg_own_mask` (bit k stands for logical address k, and several bits may be set) raises `frame_accept` and `ack_drive` in the cycle after `hdr_valid`.
- R2: In reduced listening (`cfg_full_listen`=0), a frame for a non-own, non-broadcast destination is not accepted and gets no acknowledge drive. This includes every destination when the mask is zero. Its bytes and error strobes change no flag, request no error-bit and cause no abort.
- R3: In full listening, a frame for a non-own destination is accepted without an acknowledge drive.
- R4: Destination 15 is broadcast. It is accepted in both modes and never gets an acknowledge drive, whatever the mask holds.
- R5: On a non-broadcast frame, a bit-rising error pulses `rx_abort` exactly when `cfg_rise_stop` is set. It pulses `errbit_req` only when `cfg_rise_stop` and `cfg_rise_errbit` are both set.
- R6: On a non-broadcast frame, a long-period error pulses `errbit_req` exactly when `cfg_long_errbit` is set, and it never aborts.
- R7: On a broadcast frame with `cfg_bcast_quiet`=0, a bit-rising error requests an error-bit whenever `cfg_rise_stop` is set, even with `cfg_rise_errbit` clear. A long-period error always requests one, even with `cfg_long_errbit` clear.
- R8: On a broadcast frame with `cfg_bcast_quiet`=1, neither a bit-rising error nor a long-period error requests an error-bit. The abort on a bit-rising error still follows `cfg_rise_stop`.
- R9: A short-period error requests an error-bit, except on a broadcast frame in full listening mode.
- R10: `rx_flags` holds sticky bits: [0] byte received, [1] end of reception, [2] overrun, [3] bit-rising error, [4] short-period error, [5] long-period error, [6] missing acknowledge. A bit is set one cycle after its event in an accepted frame. It is cleared only by a 1 in the same position of `flag_clr`, and a new event wins over a clear in the same cycle. All flags are 0 after reset.
- R11: Overrun [2] is set when a byte completes while byte received [0] is still set.
- R12: A last byte (`byte_valid` with `byte_last`) or an abort ends the frame, and `frame_accept` and `ack_drive` read 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_own_mask | input | 15 | One-hot own logical addresses |
| cfg_full_listen | input | 1 | 1: also receive frames for other destinations |
| cfg_rise_stop | input | 1 | Bit-rising error aborts reception |
| cfg_rise_errbit | input | 1 | Error-bit on bit-rising error (needs stop) |
| cfg_long_errbit | input | 1 | Error-bit on long-period error |
| cfg_bcast_quiet | input | 1 | Suppress rising/long error-bits on broadcast |
| hdr_valid | input | 1 | Header decoded, destination valid |
| hdr_dest | input | 4 | Header destination address |
| byte_valid | input | 1 | A data byte completed |
| byte_last | input | 1 | That byte ends the message |
| err_valid | input | 1 | Error strobes valid |
| err_rise | input | 1 | Bit-rising error |
| err_short | input | 1 | Short bit period error |
| err_long | input | 1 | Long bit period error |
| err_ack_miss | input | 1 | Missing acknowledge |
| flag_clr | input | 7 | Write-1-to-clear for rx_flags |
| frame_accept | output | 1 | Current frame is taken in |
| ack_drive | output | 1 | Drive acknowledge for current frame |
| errbit_req | output | 1 | One-cycle request for an error-bit |
| rx_abort | output | 1 | One-cycle reception abort |
| rx_flags | output | 7 | Sticky reception status |

## Verification
The assertions take for granted that the decoder raises `hdr_valid` only between frames, never in the same cycle as `byte_valid` or `err_valid`. They also assume the configuration inputs stay steady for the length of a frame, because the checks on error-bit and abort relate each pulse to the configuration one cycle earlier. The stimulus drives every field of a vector together with its header. It holds the configuration until the frame has ended and the flags have been cleared, and it issues each strobe for exactly one cycle with no other event beside it.

// File: rtl/cec_rxp_pkg.sv
// Shared types and flag positions for the receive policy block.
package cec_rxp_pkg;
    // Positions inside the sticky status vector.
    localparam int FLG_BYTE  = 0;
    localparam int FLG_END   = 1;
    localparam int FLG_OVR   = 2;
    localparam int FLG_RISE  = 3;
    localparam int FLG_SHORT = 4;
    localparam int FLG_LONG  = 5;
    localparam int FLG_ACKM  = 6;
    localparam int NUM_FLAGS = 7;

    // One cycle of error strobes from the decoder.
    typedef struct packed {
        logic rise;
        logic short_p;
        logic long_p;
        logic ack_miss;
    } err_strobe_t;
endpackage

// File: rtl/cec_rxp_addr.sv
// Destination filter. Decides acceptance and acknowledge for a frame when
// its header arrives, and holds the decision until the frame ends.
// Assumes hdr_valid is not raised in the same cycle as frame_end.
module cec_rxp_addr #(
    parameter int ADDR_W = 4,
    localparam int NDEST  = 1 << ADDR_W,
    localparam int MASK_W = NDEST - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] own_mask,
    input  logic              full_listen,
    input  logic              hdr_valid,
    input  logic [ADDR_W-1:0] hdr_dest,
    input  logic              frame_end,
    output logic              accept_q,
    output logic              ack_q,
    output logic              bcast_q
);
    localparam logic [ADDR_W-1:0] BCAST = ADDR_W'(NDEST - 1);

    logic [NDEST-1:0] dest_1h;
    logic             is_bcast;
    logic             own_hit;

    // Decode the destination and test it against the own-address mask.
    always_comb begin
        dest_1h  = NDEST'(1) << hdr_dest;
        is_bcast = (hdr_dest == BCAST);
        own_hit  = |(dest_1h[MASK_W-1:0] & own_mask);
    end

    // Latch the per-frame decision at the header and drop it at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            ack_q    <= 1'b0;
            bcast_q  <= 1'b0;
        end else if (hdr_valid) begin
            accept_q <= own_hit | is_bcast | full_listen;
            ack_q    <= own_hit;
            bcast_q  <= is_bcast;
        end else if (frame_end) begin
            accept_q <= 1'b0;
            ack_q    <= 1'b0;
            bcast_q  <= 1'b0;
        end
    end

    // R4
    bcast_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (!bcast_q && accept_q));
    // R3
    full_listen_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && full_listen) |=> accept_q);
    // R12
    end_drops_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !hdr_valid) |=> (!accept_q && !ack_q));
endmodule

// File: rtl/cec_rxp_errpol.sv
// Error-bit and abort policy. Turns the error strobes of an accepted frame
// into error-bit requests and abort pulses. Broadcast frames follow their
// own rule set. Assumes the configuration is steady during a frame.
module cec_rxp_errpol
    import cec_rxp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_ok,
    input  logic        bcast,
    input  logic        full_listen,
    input  logic        rise_stop,
    input  logic        rise_errbit,
    input  logic        long_errbit,
    input  logic        bcast_quiet,
    input  logic        err_valid,
    input  err_strobe_t err,
    output logic        abort_now,
    output logic        errbit_req,
    output logic        rx_abort
);
    logic rise_eb, long_eb, short_eb, eb_now;

    // Per-error eligibility; the broadcast rules override the enables.
    always_comb begin
        rise_eb   = bcast ? (!bcast_quiet && rise_stop) : (rise_stop && rise_errbit);
        long_eb   = bcast ? !bcast_quiet : long_errbit;
        short_eb  = !(bcast && full_listen);
        eb_now    = frame_ok && err_valid &&
                    ((err.rise && rise_eb) || (err.short_p && short_eb) ||
                     (err.long_p && long_eb));
        abort_now = frame_ok && err_valid && err.rise && rise_stop;
    end

    // Register the decisions into one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            errbit_req <= 1'b0;
            rx_abort   <= 1'b0;
        end else begin
            errbit_req <= eb_now;
            rx_abort   <= abort_now;
        end
    end

    // R5
    abort_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |-> $past(rise_stop && err.rise && err_valid));
    // R8
    quiet_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (errbit_req && $past(bcast && bcast_quiet)) |-> $past(err.short_p));
    // R9
    short_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (errbit_req && $past(bcast && full_listen)) |-> $past(err.rise || err.long_p));
    // R2
    no_frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> (!errbit_req && !rx_abort));
endmodule

// File: rtl/cec_rxp_status.sv
// Sticky reception flags with write-1-to-clear. A new event wins over a
// clear in the same cycle. Events count only inside an accepted frame.
module cec_rxp_status
    import cec_rxp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_ok,
    input  logic                 byte_valid,
    input  logic                 byte_last,
    input  logic                 err_valid,
    input  err_strobe_t          err,
    input  logic [NUM_FLAGS-1:0] clr,
    output logic [NUM_FLAGS-1:0] flags
);
    logic [NUM_FLAGS-1:0] set_v;

    // Map events of this cycle onto flag positions.
    always_comb begin
        set_v            = '0;
        set_v[FLG_BYTE]  = frame_ok && byte_valid;
        set_v[FLG_END]   = frame_ok && byte_valid && byte_last;
        set_v[FLG_OVR]   = frame_ok && byte_valid && flags[FLG_BYTE];
        set_v[FLG_RISE]  = frame_ok && err_valid && err.rise;
        set_v[FLG_SHORT] = frame_ok && err_valid && err.short_p;
        set_v[FLG_LONG]  = frame_ok && err_valid && err.long_p;
        set_v[FLG_ACKM]  = frame_ok && err_valid && err.ack_miss;
    end

    // Hold flags until cleared; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_v;
    end

    // R11
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_OVR]) |-> $past(flags[FLG_BYTE]));

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sticky
        // R10
        sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(clr[i]));
    end
endmodule

// File: rtl/cec_rx_policy.sv
// Top of the receive policy block: destination filter, error-bit policy
// and sticky status. Assumes the decoder delivers one header per frame and
// one-cycle strobes for bytes and errors.
module cec_rx_policy
    import cec_rxp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [14:0] cfg_own_mask,
    input  logic        cfg_full_listen,
    input  logic        cfg_rise_stop,
    input  logic        cfg_rise_errbit,
    input  logic        cfg_long_errbit,
    input  logic        cfg_bcast_quiet,
    input  logic        hdr_valid,
    input  logic [3:0]  hdr_dest,
    input  logic        byte_valid,
    input  logic        byte_last,
    input  logic        err_valid,
    input  logic        err_rise,
    input  logic        err_short,
    input  logic        err_long,
    input  logic        err_ack_miss,
    input  logic [6:0]  flag_clr,
    output logic        frame_accept,
    output logic        ack_drive,
    output logic        errbit_req,
    output logic        rx_abort,
    output logic [6:0]  rx_flags
);
    err_strobe_t err_s;
    logic        bcast_q;
    logic        abort_now;
    logic        frame_end;

    // Bundle strobes and form the end-of-frame event.
    always_comb begin
        err_s     = '{rise: err_rise, short_p: err_short,
                      long_p: err_long, ack_miss: err_ack_miss};
        frame_end = (frame_accept && byte_valid && byte_last) || abort_now;
    end

    cec_rxp_addr #(.ADDR_W(4)) u_addr (
        .clk(clk), .rst_n(rst_n), .own_mask(cfg_own_mask),
        .full_listen(cfg_full_listen), .hdr_valid(hdr_valid),
        .hdr_dest(hdr_dest), .frame_end(frame_end),
        .accept_q(frame_accept), .ack_q(ack_drive), .bcast_q(bcast_q)
    );

    cec_rxp_errpol u_errpol (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_accept), .bcast(bcast_q),
        .full_listen(cfg_full_listen), .rise_stop(cfg_rise_stop),
        .rise_errbit(cfg_rise_errbit), .long_errbit(cfg_long_errbit),
        .bcast_quiet(cfg_bcast_quiet), .err_valid(err_valid), .err(err_s),
        .abort_now(abort_now), .errbit_req(errbit_req), .rx_abort(rx_abort)
    );

    cec_rxp_status u_status (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_accept),
        .byte_valid(byte_valid), .byte_last(byte_last),
        .err_valid(err_valid), .err(err_s), .clr(flag_clr), .flags(rx_flags)
    );
endmodule

// File: tb/cec_rx_policy_bench.sv
module cec_rx_policy_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] cfg_own_mask;
    logic        cfg_full_listen, cfg_rise_stop, cfg_rise_errbit;
    logic        cfg_long_errbit, cfg_bcast_quiet;
    logic        hdr_valid;
    logic [3:0]  hdr_dest;
    logic        byte_valid, byte_last;
    logic        err_valid, err_rise, err_short, err_long, err_ack_miss;
    logic [6:0]  flag_clr;
    logic        frame_accept, ack_drive, errbit_req, rx_abort;
    logic [6:0]  rx_flags;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    cec_rx_policy u_cec_rx_policy (.*);

    typedef struct packed {
        logic [3:0]  req;
        logic [14:0] mask;
        logic        full, stop, grise, glong, quiet;
        logic [3:0]  dest;
        logic [2:0]  err;   // {rise, short, long}
        logic        acc, ack, eb, ab;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 15'h0004, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2,  3'b000, 1'b1,1'b1,1'b0,1'b0}, // R1
        '{4'd1, 15'h0104, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd8,  3'b000, 1'b1,1'b1,1'b0,1'b0}, // R1
        '{4'd2, 15'h0004, 1'b0,1'b1,1'b1,1'b0,1'b0, 4'd5,  3'b100, 1'b0,1'b0,1'b0,1'b0}, // R2
        '{4'd3, 15'h0004, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd5,  3'b010, 1'b1,1'b0,1'b1,1'b0}, // R3
        '{4'd2, 15'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd0,  3'b000, 1'b0,1'b0,1'b0,1'b0}, // R2
        '{4'd4, 15'h0004, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd15, 3'b000, 1'b1,1'b0,1'b0,1'b0}, // R4
        '{4'd5, 15'h0004, 1'b0,1'b1,1'b1,1'b0,1'b0, 4'd2,  3'b100, 1'b1,1'b1,1'b1,1'b1}, // R5
        '{4'd5, 15'h0004, 1'b0,1'b1,1'b0,1'b0,1'b0, 4'd2,  3'b100, 1'b1,1'b1,1'b0,1'b1}, // R5
        '{4'd5, 15'h0004, 1'b0,1'b0,1'b1,1'b0,1'b0, 4'd2,  3'b100, 1'b1,1'b1,1'b0,1'b0}, // R5
        '{4'd6, 15'h0004, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd2,  3'b001, 1'b1,1'b1,1'b1,1'b0}, // R6
        '{4'd6, 15'h0004, 1'b0,1'b1,1'b1,1'b0,1'b0, 4'd2,  3'b001, 1'b1,1'b1,1'b0,1'b0}, // R6
        '{4'd7, 15'h0004, 1'b0,1'b1,1'b0,1'b0,1'b0, 4'd15, 3'b100, 1'b1,1'b0,1'b1,1'b1}, // R7
        '{4'd7, 15'h0004, 1'b0,1'b0,1'b1,1'b0,1'b0, 4'd15, 3'b100, 1'b1,1'b0,1'b0,1'b0}, // R7
        '{4'd7, 15'h0004, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd15, 3'b001, 1'b1,1'b0,1'b1,1'b0}, // R7
        '{4'd8, 15'h0004, 1'b0,1'b0,1'b0,1'b1,1'b1, 4'd15, 3'b001, 1'b1,1'b0,1'b0,1'b0}, // R8
        '{4'd8, 15'h0004, 1'b0,1'b1,1'b1,1'b1,1'b1, 4'd15, 3'b100, 1'b1,1'b0,1'b0,1'b1}, // R8
        '{4'd9, 15'h0004, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd15, 3'b010, 1'b1,1'b0,1'b0,1'b0}, // R9
        '{4'd9, 15'h0004, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd15, 3'b010, 1'b1,1'b0,1'b1,1'b0}, // R9
        '{4'd9, 15'h0004, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd2,  3'b010, 1'b1,1'b1,1'b1,1'b0}, // R9
        '{4'd4, 15'h7FFF, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd15, 3'b000, 1'b1,1'b0,1'b0,1'b0}  // R4
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_flags();
        flag_clr = 7'h7F;
        step();
        flag_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_own_mask = '0; cfg_full_listen = 0; cfg_rise_stop = 0;
        cfg_rise_errbit = 0; cfg_long_errbit = 0; cfg_bcast_quiet = 0;
        hdr_valid = 0; hdr_dest = '0; byte_valid = 0; byte_last = 0;
        err_valid = 0; err_rise = 0; err_short = 0; err_long = 0;
        err_ack_miss = 0; flag_clr = '0;
        repeat (3) step();
        chk("R10 reset flags", 32'(rx_flags), 0);
        chk("R12 reset accept", 32'(frame_accept), 0);
        chk("R12 reset ack", 32'(ack_drive), 0);
        chk("R5 reset errbit/abort", 32'({errbit_req, rx_abort}), 0);
        rst_n = 1'b1;
        step();

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            cfg_own_mask = v.mask; cfg_full_listen = v.full;
            cfg_rise_stop = v.stop; cfg_rise_errbit = v.grise;
            cfg_long_errbit = v.glong; cfg_bcast_quiet = v.quiet;
            hdr_dest = v.dest; hdr_valid = 1;
            step();
            hdr_valid = 0;
            chk($sformatf("R%0d vec%0d accept", v.req, i), 32'(frame_accept), 32'(v.acc));
            chk($sformatf("R%0d vec%0d ack", v.req, i), 32'(ack_drive), 32'(v.ack));
            if (v.err != 3'b000) begin
                err_valid = 1; err_rise = v.err[2]; err_short = v.err[1]; err_long = v.err[0];
                step();
                err_valid = 0; err_rise = 0; err_short = 0; err_long = 0;
                chk($sformatf("R%0d vec%0d errbit", v.req, i), 32'(errbit_req), 32'(v.eb));
                chk($sformatf("R%0d vec%0d abort", v.req, i), 32'(rx_abort), 32'(v.ab));
            end
            if (!v.ab) begin
                byte_valid = 1; byte_last = 1;
                step();
                byte_valid = 0; byte_last = 0;
            end
            chk($sformatf("R12 vec%0d accept after end", i), 32'(frame_accept), 0);
            chk($sformatf("R12 vec%0d ack after end", i), 32'(ack_drive), 0);
            clear_flags();
        end

        // Directed: sticky flags, overrun, clear, end of reception.
        cfg_own_mask = 15'h0004; cfg_full_listen = 0; cfg_rise_stop = 0;
        cfg_rise_errbit = 0; cfg_long_errbit = 0; cfg_bcast_quiet = 0;
        hdr_dest = 4'd2; hdr_valid = 1; step(); hdr_valid = 0;
        byte_valid = 1; step(); byte_valid = 0;
        chk("R10 byte flag", 32'(rx_flags), 32'h01);
        byte_valid = 1; step(); byte_valid = 0;
        chk("R11 overrun", 32'(rx_flags), 32'h05);
        flag_clr = 7'h01; step(); flag_clr = '0;
        chk("R10 clear one bit", 32'(rx_flags), 32'h04);
        byte_valid = 1; flag_clr = 7'h01; step(); byte_valid = 0; flag_clr = '0;
        chk("R10 set beats clear", 32'(rx_flags), 32'h05);
        flag_clr = 7'h01; step(); flag_clr = '0;
        err_valid = 1; err_short = 1; err_ack_miss = 1; step();
        err_valid = 0; err_short = 0; err_ack_miss = 0;
        chk("R10 short and ack-miss flags", 32'(rx_flags), 32'h54);
        chk("R9 short errbit own frame", 32'(errbit_req), 1);
        byte_valid = 1; byte_last = 1; step(); byte_valid = 0; byte_last = 0;
        chk("R10 end of reception", 32'(rx_flags), 32'h57);
        chk("R12 accept after last byte", 32'(frame_accept), 0);
        clear_flags();
        chk("R10 clear all", 32'(rx_flags), 0);

        // Directed: rising error in aborting frame sets its flag.
        cfg_rise_stop = 1;
        hdr_valid = 1; step(); hdr_valid = 0;
        err_valid = 1; err_rise = 1; step(); err_valid = 0; err_rise = 0;
        chk("R10 rise flag on abort", 32'(rx_flags), 32'h08);
        chk("R12 accept after abort", 32'(frame_accept), 0);
        clear_flags();

        // Directed: ignored frame leaves flags and outputs untouched.
        hdr_dest = 4'd5; hdr_valid = 1; step(); hdr_valid = 0;
        err_valid = 1; err_long = 1; err_rise = 1; step();
        err_valid = 0; err_long = 0; err_rise = 0;
        chk("R2 ignored frame errbit", 32'({errbit_req, rx_abort}), 0);
        byte_valid = 1; byte_last = 1; step(); byte_valid = 0; byte_last = 0;
        chk("R2 ignored frame flags", 32'(rx_flags), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule